// File: doc/BRIEF.md
# Transceiver Power-Saving Mode Controller

This block decides the power state of a 10/100 Ethernet transceiver. It watches writes to two management registers and keeps three control bits: power-down in register 0, analog-off and link-down power saving in register 17. From those bits, the link-status flag and a receive-energy flag it drives the enables for the analog transmitter, the analog receiver, the PLL, the crystal oscillator, the core digital logic and the link-pulse transmitter. It also emits a one-cycle beacon strobe that stands in for normal link pulses while the link is down.

Power-down switches off everything except the management interface, so the only way out is a management write that clears the power-down bit. Analog-off keeps the oscillator and the core logic running so the analog side can be brought back. In link-down power saving, the block stops normal link signalling and sends sparse beacons while the cable is quiet, then returns to normal signalling as soon as receive energy appears. After analog-off or power-down ends, a ready output stays low long enough for the PLL to relock.

Top module: `phy_pwr_ctl`

## Requirements
- R1: After reset all three control bits are clear: all six enables are 1, `beacon` is 0 and `ready` is 1.
- R2: A write to address 0 with data bit 11 set enters power-down on the next cycle: all six enables (oscillator and core included) are 0 and `ready` is 0.
- R3: Power-down is left only by a write to address 0 with data bit 11 clear; writes to address 17 during power-down are stored and take effect once power-down ends, while the enables stay 0.
- R4: A write to address 17 with data bit 11 set enters analog-off: transmitter, receiver, PLL and link-pulse enables are 0, oscillator and core enables are 1, and `ready` is 0.
- R5: Priority is power-down, then analog-off, then link-down saving: with several bits set, the highest one sets the enables, and no beacon is sent unless link-down saving is the active mode.
- R6: With address 17 bit 12 set and no other mode active, when the link is down and no receive energy is present, the link-pulse enable drops one cycle later and `beacon` pulses for exactly one cycle every `BEACON_CYC` cycles.
- R7: In the quiet state, a cycle with receive energy shows no beacon, the link-pulse enable returns to 1 on the next cycle, and no beacon appears while energy stays present.
- R8: In link-down saving with the link up, the link-pulse enable stays 1 and no beacon is produced.
- R9: When analog-off or power-down ends, `ready` stays 0 for exactly `SETTLE_CYC` further cycles, then rises.
- R10: Writes to other addresses, writes to other data bits of addresses 0 and 17, and data presented with `reg_wr` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, kept running in every mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Management register write strobe |
| reg_addr | input | ADDR_W | Register address of the write |
| reg_wdata | input | DATA_W | Register write data |
| link_up | input | 1 | Link status, 1 when the link is established |
| rx_energy | input | 1 | Receiver reports signal energy on the line |
| en_afe_tx | output | 1 | Analog transmitter enable |
| en_afe_rx | output | 1 | Analog receiver enable |
| en_pll | output | 1 | PLL enable |
| en_osc | output | 1 | Crystal oscillator enable |
| en_core | output | 1 | Core digital logic enable |
| en_lpulse | output | 1 | Normal link pulse / idle transmitter enable |
| beacon | output | 1 | One-cycle low-power beacon strobe |
| ready | output | 1 | Data path may run (PLL settled) |

## Verification
A wrong control bit shows on the enables in the cycle right after the write edge, since the enables follow the stored bits without further registers. A wrong quiet state shows one cycle after the link or energy change, as a link-pulse enable at the wrong level; a wrong beacon count only shows when the strobe lands a cycle early or late, up to `BEACON_CYC` cycles later. A wrong settle count shows as a `ready` edge displaced from the expected cycle, at most `SETTLE_CYC` cycles after the mode ends.

// File: rtl/phy_pwr_pkg.sv
`timescale 1ns/1ps
package phy_pwr_pkg;

   typedef enum logic [1:0] {
      PM_NORMAL = 2'd0,
      PM_LDPS   = 2'd1,
      PM_AOFF   = 2'd2,
      PM_PWD    = 2'd3
   } pwr_mode_e;

   typedef enum logic {
      LS_ACTIVE = 1'b0,
      LS_QUIET  = 1'b1
   } ldps_st_e;

   typedef struct packed {
      logic afe_tx;
      logic afe_rx;
      logic pll;
      logic osc;
      logic core;
      logic lpulse;
   } pwr_en_s;

endpackage

// File: rtl/pwr_ctl_regs.sv
`timescale 1ns/1ps
module pwr_ctl_regs #(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int PWD_ADDR = 0,
   parameter int PWD_BIT  = 11,
   parameter int CFG_ADDR = 17,
   parameter int AOFF_BIT = 11,
   parameter int LDPS_BIT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              pwd_q,
   output logic              aoff_q,
   output logic              ldps_q
);

   localparam logic [ADDR_W-1:0] PwdA = ADDR_W'(PWD_ADDR);
   localparam logic [ADDR_W-1:0] CfgA = ADDR_W'(CFG_ADDR);

   logic hit_pwd;
   logic hit_cfg;
   logic unused_wdata;

   assign hit_pwd      = wr && (addr == PwdA);
   assign hit_cfg      = wr && (addr == CfgA);
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwd_q <= 1'b0;
      end else if (hit_pwd) begin
         pwd_q <= wdata[PWD_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aoff_q <= 1'b0;
         ldps_q <= 1'b0;
      end else if (hit_cfg) begin
         aoff_q <= wdata[AOFF_BIT];
         ldps_q <= wdata[LDPS_BIT];
      end
   end

endmodule

// File: rtl/pwr_mode_arb.sv
`timescale 1ns/1ps
module pwr_mode_arb
   import phy_pwr_pkg::*;
(
   input  logic      pwd_q,
   input  logic      aoff_q,
   input  logic      ldps_q,
   output pwr_mode_e mode
);

   always_comb begin
      if (pwd_q) begin
         mode = PM_PWD;
      end else if (aoff_q) begin
         mode = PM_AOFF;
      end else if (ldps_q) begin
         mode = PM_LDPS;
      end else begin
         mode = PM_NORMAL;
      end
   end

endmodule

// File: rtl/ldps_beacon.sv
`timescale 1ns/1ps
module ldps_beacon
   import phy_pwr_pkg::*;
#(
   parameter int BEACON_CYC = 400000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic link_up,
   input  logic rx_energy,
   output logic quiet,
   output logic beacon
);

   localparam int CNT_W = (BEACON_CYC > 2) ? $clog2(BEACON_CYC) : 1;
   localparam logic [CNT_W-1:0] LastCnt = CNT_W'(BEACON_CYC - 1);

   ldps_st_e         st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             wake;

   assign wake = rx_energy || link_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= LS_ACTIVE;
         cnt_q <= '0;
      end else if (!active) begin
         st_q  <= LS_ACTIVE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            LS_QUIET: begin
               if (wake) begin
                  st_q  <= LS_ACTIVE;
                  cnt_q <= '0;
               end else if (cnt_q == LastCnt) begin
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               cnt_q <= '0;
               if (!wake) begin
                  st_q <= LS_QUIET;
               end
            end
         endcase
      end
   end

   assign quiet  = (st_q == LS_QUIET);
   assign beacon = active && quiet && !wake && (cnt_q == LastCnt);

endmodule

// File: rtl/settle_timer.sv
`timescale 1ns/1ps
module settle_timer #(
   parameter int SETTLE_CYC = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic ready
);

   generate
      if (SETTLE_CYC == 0) begin : g_none
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign ready      = !hold;
      end else begin : g_count
         localparam int CNT_W = $clog2(SETTLE_CYC + 1);
         localparam logic [CNT_W-1:0] Load = CNT_W'(SETTLE_CYC);

         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (hold) begin
               cnt_q <= Load;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign ready = !hold && (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/phy_pwr_ctl.sv
`timescale 1ns/1ps
module phy_pwr_ctl
   import phy_pwr_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 16,
   parameter int PWD_ADDR   = 0,
   parameter int PWD_BIT    = 11,
   parameter int CFG_ADDR   = 17,
   parameter int AOFF_BIT   = 11,
   parameter int LDPS_BIT   = 12,
   parameter int BEACON_CYC = 400000,
   parameter int SETTLE_CYC = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              link_up,
   input  logic              rx_energy,
   output logic              en_afe_tx,
   output logic              en_afe_rx,
   output logic              en_pll,
   output logic              en_osc,
   output logic              en_core,
   output logic              en_lpulse,
   output logic              beacon,
   output logic              ready
);

   generate
      if (BEACON_CYC < 2) begin : g_bad_beacon
         $error("BEACON_CYC must be at least 2");
      end
      if (SETTLE_CYC < 0) begin : g_bad_settle
         $error("SETTLE_CYC must not be negative");
      end
      if (PWD_BIT >= DATA_W || AOFF_BIT >= DATA_W || LDPS_BIT >= DATA_W) begin : g_bad_bit
         $error("control bit positions must lie inside DATA_W");
      end
      if (AOFF_BIT == LDPS_BIT) begin : g_bad_overlap
         $error("AOFF_BIT and LDPS_BIT must differ");
      end
      if (PWD_ADDR == CFG_ADDR) begin : g_bad_addr
         $error("PWD_ADDR and CFG_ADDR must differ");
      end
      if (PWD_ADDR >= (1 << ADDR_W) || CFG_ADDR >= (1 << ADDR_W)) begin : g_bad_aw
         $error("register addresses must fit in ADDR_W");
      end
   endgenerate

   logic      pwd_q;
   logic      aoff_q;
   logic      ldps_q;
   pwr_mode_e mode;
   logic      quiet;
   logic      hold;
   pwr_en_s   en;

   pwr_ctl_regs #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .PWD_ADDR(PWD_ADDR),
      .PWD_BIT (PWD_BIT),
      .CFG_ADDR(CFG_ADDR),
      .AOFF_BIT(AOFF_BIT),
      .LDPS_BIT(LDPS_BIT)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .pwd_q (pwd_q),
      .aoff_q(aoff_q),
      .ldps_q(ldps_q)
   );

   pwr_mode_arb u_arb (
      .pwd_q (pwd_q),
      .aoff_q(aoff_q),
      .ldps_q(ldps_q),
      .mode  (mode)
   );

   ldps_beacon #(
      .BEACON_CYC(BEACON_CYC)
   ) u_beacon (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (mode == PM_LDPS),
      .link_up  (link_up),
      .rx_energy(rx_energy),
      .quiet    (quiet),
      .beacon   (beacon)
   );

   assign hold = (mode == PM_PWD) || (mode == PM_AOFF);

   settle_timer #(
      .SETTLE_CYC(SETTLE_CYC)
   ) u_settle (
      .clk  (clk),
      .rst_n(rst_n),
      .hold (hold),
      .ready(ready)
   );

   always_comb begin
      en = '1;
      case (mode)
         PM_PWD: begin
            en = '0;
         end
         PM_AOFF: begin
            en      = '0;
            en.osc  = 1'b1;
            en.core = 1'b1;
         end
         PM_LDPS: begin
            en.lpulse = !quiet;
         end
         default: begin
            en = '1;
         end
      endcase
   end

   assign en_afe_tx = en.afe_tx;
   assign en_afe_rx = en.afe_rx;
   assign en_pll    = en.pll;
   assign en_osc    = en.osc;
   assign en_core   = en.core;
   assign en_lpulse = en.lpulse;

endmodule

// File: rtl/phy_pwr_chk.sv
`timescale 1ns/1ps
module phy_pwr_chk #(
   parameter int ADDR_W     = 5,
   parameter int PWD_ADDR   = 0,
   parameter int SETTLE_CYC = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              link_up,
   input logic              rx_energy,
   input logic              pwd_q,
   input logic              aoff_q,
   input logic              ldps_q,
   input logic              en_afe_tx,
   input logic              en_afe_rx,
   input logic              en_pll,
   input logic              en_osc,
   input logic              en_core,
   input logic              en_lpulse,
   input logic              beacon,
   input logic              ready
);

   AST_PWD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      pwd_q |-> !(en_afe_tx || en_afe_rx || en_pll || en_osc || en_core || en_lpulse || ready)); // R2

   AST_PWD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pwd_q && !(reg_wr && reg_addr == ADDR_W'(PWD_ADDR))) |=> pwd_q); // R3

   AST_AOFF_OSC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwd_q && aoff_q) |-> (en_osc && en_core && !en_pll && !en_afe_tx && !en_afe_rx && !en_lpulse)); // R4

   AST_BEACON_ONLY_LDPS: assert property (@(posedge clk) disable iff (!rst_n)
      beacon |-> (ldps_q && !aoff_q && !pwd_q && !en_lpulse)); // R5

   AST_BEACON_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      beacon |=> !beacon); // R6

   AST_NO_BEACON_ON_ENERGY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_energy |-> !beacon); // R7

   AST_NO_BEACON_LINK_UP: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |-> !beacon); // R8

   AST_READY_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      (SETTLE_CYC > 0 && (pwd_q || aoff_q)) |=> !ready); // R9

endmodule

bind phy_pwr_ctl phy_pwr_chk #(
   .ADDR_W    (ADDR_W),
   .PWD_ADDR  (PWD_ADDR),
   .SETTLE_CYC(SETTLE_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .link_up  (link_up),
   .rx_energy(rx_energy),
   .pwd_q    (pwd_q),
   .aoff_q   (aoff_q),
   .ldps_q   (ldps_q),
   .en_afe_tx(en_afe_tx),
   .en_afe_rx(en_afe_rx),
   .en_pll   (en_pll),
   .en_osc   (en_osc),
   .en_core  (en_core),
   .en_lpulse(en_lpulse),
   .beacon   (beacon),
   .ready    (ready)
);

// File: tb/phy_pwr_ctl_tb.sv
`timescale 1ns/1ps
module phy_pwr_ctl_tb;

   localparam int B = 10;
   localparam int S = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        link_up = 1'b1;
   logic        rx_energy = 1'b0;
   logic        en_afe_tx, en_afe_rx, en_pll, en_osc, en_core, en_lpulse;
   logic        beacon, ready;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   phy_pwr_ctl #(
      .BEACON_CYC(B),
      .SETTLE_CYC(S)
   ) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .link_up  (link_up),
      .rx_energy(rx_energy),
      .en_afe_tx(en_afe_tx),
      .en_afe_rx(en_afe_rx),
      .en_pll   (en_pll),
      .en_osc   (en_osc),
      .en_core  (en_core),
      .en_lpulse(en_lpulse),
      .beacon   (beacon),
      .ready    (ready)
   );

   // behavioural reference model
   int m_pwd = 0, m_aoff = 0, m_ldps = 0, m_quiet = 0, m_bcnt = 0, m_settle = 0;

   function automatic int m_mode();
      if (m_pwd != 0) return 3;
      if (m_aoff != 0) return 2;
      if (m_ldps != 0) return 1;
      return 0;
   endfunction

   always @(posedge clk) begin
      int md;
      bit wake;
      md   = m_mode();
      wake = rx_energy || link_up;
      if (!rst_n) begin
         m_pwd <= 0; m_aoff <= 0; m_ldps <= 0;
         m_quiet <= 0; m_bcnt <= 0; m_settle <= 0;
      end else begin
         if (reg_wr && reg_addr == 5'd0) m_pwd <= int'(reg_wdata[11]);
         if (reg_wr && reg_addr == 5'd17) begin
            m_aoff <= int'(reg_wdata[11]);
            m_ldps <= int'(reg_wdata[12]);
         end
         if (md != 1) begin
            m_quiet <= 0; m_bcnt <= 0;
         end else if (m_quiet != 0) begin
            if (wake) begin m_quiet <= 0; m_bcnt <= 0; end
            else m_bcnt <= (m_bcnt + 1) % B;
         end else begin
            m_quiet <= wake ? 0 : 1;
            m_bcnt  <= 0;
         end
         if (md >= 2) m_settle <= S;
         else if (m_settle > 0) m_settle <= m_settle - 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always begin
      @(negedge clk);
      #2;
      if (rst_n) begin
         int md;
         logic [5:0] exp_en;
         string req;
         bit e_beacon, e_ready;
         md = m_mode();
         case (md)
            3: begin exp_en = 6'b000000; req = "R2"; end
            2: begin exp_en = 6'b000110; req = "R4"; end
            1: begin exp_en = {5'b11111, (m_quiet == 0)}; req = "R6"; end
            default: begin exp_en = 6'b111111; req = "R1"; end
         endcase
         e_beacon = (md == 1) && (m_quiet != 0) && (m_bcnt == B - 1) && !rx_energy && !link_up;
         e_ready  = (md < 2) && (m_settle == 0);
         chk({en_afe_tx, en_afe_rx, en_pll, en_osc, en_core, en_lpulse} == exp_en, req,
             "enables", int'({en_afe_tx, en_afe_rx, en_pll, en_osc, en_core, en_lpulse}), int'(exp_en));
         chk(beacon == e_beacon, "R6", "beacon", int'(beacon), int'(e_beacon));
         chk(ready == e_ready, "R9", "ready", int'(ready), int'(e_ready));
      end
   end

   function automatic logic [5:0] env();
      return {en_afe_tx, en_afe_rx, en_pll, en_osc, en_core, en_lpulse};
   endfunction

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic measure_settle(input string req);
      int n;
      n = 0;
      #3;
      while (!ready && n < 100) begin
         n++;
         @(negedge clk);
         #3;
      end
      chk(n == S, req, "ready low cycles", n, S);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      int cnt;
      int last;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #3;
      // R1: reset state
      chk(env() == 6'h3F, "R1", "enables after reset", int'(env()), 63);
      chk(beacon == 1'b0, "R1", "beacon after reset", int'(beacon), 0);
      chk(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);

      // R10: unrelated writes and data without strobe
      wr(5'd1, 16'hFFFF);
      wr(5'd17, 16'hE7FF);
      wr(5'd0, 16'hF7FF);
      @(negedge clk);
      reg_addr = 5'd0; reg_wdata = 16'h0800;
      repeat (2) @(negedge clk);
      reg_wdata = '0;
      #3;
      chk(env() == 6'h3F, "R10", "enables after ignored writes", int'(env()), 63);
      chk(ready == 1'b1, "R10", "ready after ignored writes", int'(ready), 1);

      // R4: analog-off
      wr(5'd17, 16'h0800);
      #3;
      chk(env() == 6'b000110, "R4", "analog-off enables", int'(env()), 6);
      chk(ready == 1'b0, "R4", "ready in analog-off", int'(ready), 0);
      repeat (3) @(negedge clk);
      // R9: settle after analog-off
      wr(5'd17, 16'h0000);
      measure_settle("R9");

      // R2: power-down
      wr(5'd0, 16'h0800);
      #3;
      chk(env() == 6'b000000, "R2", "power-down enables", int'(env()), 0);
      chk(ready == 1'b0, "R2", "ready in power-down", int'(ready), 0);
      // R3: register stays writable, enables stay off
      wr(5'd17, 16'h0800);
      repeat (2) @(negedge clk);
      #3;
      chk(env() == 6'b000000, "R3", "enables after cfg write in power-down", int'(env()), 0);
      wr(5'd0, 16'h0000);
      #3;
      chk(env() == 6'b000110, "R3", "stored analog-off after power-down exit", int'(env()), 6);
      wr(5'd17, 16'h0000);
      measure_settle("R9");

      // R5: priority with link down
      link_up = 1'b0;
      wr(5'd17, 16'h1800);
      cnt = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk); #3;
         if (beacon) cnt++;
      end
      chk(cnt == 0, "R5", "beacons under analog-off", cnt, 0);
      chk(env() == 6'b000110, "R5", "analog-off over saving", int'(env()), 6);
      wr(5'd0, 16'h0800);
      #3;
      chk(env() == 6'b000000, "R5", "power-down over analog-off", int'(env()), 0);
      wr(5'd0, 16'h0000);
      #3;
      chk(env() == 6'b000110, "R5", "analog-off after power-down clear", int'(env()), 6);

      // R6: beacon spacing in link-down saving
      wr(5'd17, 16'h1000);
      cnt = 0;
      last = -1;
      for (int i = 0; i < 45; i++) begin
         @(negedge clk); #3;
         if (beacon) begin
            if (last >= 0) chk(i - last == B, "R6", "beacon spacing", i - last, B);
            last = i;
            cnt++;
         end
      end
      chk(cnt == 4, "R6", "beacons in window", cnt, 4);
      chk(en_lpulse == 1'b0, "R6", "link pulses off while quiet", int'(en_lpulse), 0);

      // R7: energy suppresses the beacon that was due
      while (!beacon) begin
         @(negedge clk); #3;
      end
      repeat (9) @(negedge clk);
      @(negedge clk);
      rx_energy = 1'b1;
      #3;
      chk(beacon == 1'b0, "R7", "beacon on energy cycle", int'(beacon), 0);
      chk(en_lpulse == 1'b0, "R7", "link pulses still off", int'(en_lpulse), 0);
      @(negedge clk); #3;
      chk(en_lpulse == 1'b1, "R7", "link pulses resume", int'(en_lpulse), 1);
      cnt = 0;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk); #3;
         if (beacon) cnt++;
      end
      chk(cnt == 0, "R7", "beacons while energy present", cnt, 0);
      @(negedge clk);
      rx_energy = 1'b0;
      repeat (14) @(negedge clk);

      // R8: link up in saving mode
      @(negedge clk);
      link_up = 1'b1;
      repeat (2) @(negedge clk);
      cnt = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk); #3;
         if (beacon) cnt++;
      end
      chk(cnt == 0, "R8", "beacons with link up", cnt, 0);
      chk(en_lpulse == 1'b1, "R8", "link pulses with link up", int'(en_lpulse), 1);

      wr(5'd17, 16'h0000);
      repeat (5) @(negedge clk);
      summary();
      $finish;
   end

endmodule